// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Cache

This block makes a serial flash device look like a read-only region of memory. A requester issues 32-bit reads on a simple request/ready port. Each read is compared against a single buffered line of 1 KB. On a hit, the word comes straight out of the line buffer. On a miss, the block runs a read command on the serial byte engine and refills the entire line from the flash. It then answers the read from the freshly loaded line.

The serial side is a byte-at-a-time stream. The block offers one byte with a valid strobe, and the shifter takes it with a ready strobe. One received byte comes back per transmitted byte. The command framing is taken from a configuration register held inside the block and written through a strobe/data pair:

- the instruction code;
- whether a mode byte is sent, and its value;
- the number of dummy bytes;
- whether the address is split across two parallel buses.

The flash address is the bus address divided by the effective bus count. Bit 24 of that flash address drives an upper-page output for the whole refill. The output returns to its idle value once the refill ends.

Top module: `lin_flash_cache`

## Requirements
- R1: After reset, rd_ready is 1, and rd_valid, tx_valid and upper_page are 0, and cs_n is 1.
- R2: The configuration register resets to 0x03A002EB. The first miss after reset therefore sends instruction 0xEB, three address bytes, mode byte 0xA0 and two dummy bytes.
- R3: A read of byte address A hits when the line is valid and base <= A <= base + 1020. A hit returns line word (A - base)/4 with rd_valid high exactly two cycles after the accepting edge, and causes no serial traffic.
- R4: A miss sends, in this order: config bits 7:0, then flash address bits 23:16, 15:8 and 7:0. If config bit 25 is 1, a mode byte from config bits 23:16 follows. Last come config bits 10:8 zero bytes.
- R5: The flash address is A >> log2(BUS_CNT) when config bit 30 is 1, and A otherwise. During a refill, upper_page equals bit 24 of the flash address.
- R6: After the command bytes, exactly 1024 zero bytes are sent. The bytes received during the command are discarded. Each four received data bytes form one line word, first byte in bits 7:0.
- R7: After the last data byte, cs_n returns to 1 and upper_page returns to 0. The line base becomes the missed address, and the missed read is answered from the new line.
- R8: Any write to the configuration register invalidates the line, so the next read misses even inside the old window.
- R9: While a refill is running, rd_ready is 0 and a request is neither accepted nor answered.
- R10: cs_n stays 0 from the first command byte to the last data byte, and every byte offered on tx has cs_n at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_ready | output | 1 | Request accepted when high together with rd_req |
| rd_valid | output | 1 | One-cycle response strobe |
| rd_data | output | 32 | Read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Byte to shift out |
| tx_ready | input | 1 | Shifter takes the offered byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| cs_n | output | 1 | Active-low flash select |
| upper_page | output | 1 | Upper flash page / second device select |

## Verification
The assertions watch, on every cycle, the properties that relate the port strobes to each other:

- a byte is only offered while cs_n is 0;
- the ready signal stays low during a refill;
- upper_page is 0 whenever cs_n is 1;
- each response is a single pulse;
- only one byte is in flight at a time.

Only the scenarios can show the rest, because it depends on values and ordering across thousands of cycles:

- the exact command bytes;
- the address division and page bit;
- the byte packing of the line;
- the hit window edges at base+1020 and base+1024;
- invalidation by a configuration write.

// File: rtl/lqc_pkg.sv
package lqc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_OUT,
    ST_SEND,
    ST_WAIT
  } lqc_state_e;

  localparam logic [31:0] CFG_RESET    = 32'h03A0_02EB;
  localparam int          CFG_DUAL_BIT = 30;
  localparam int          CFG_MODE_BIT = 25;
  localparam int          CFG_MODE_LSB = 16;
  localparam int          CFG_DUMY_LSB = 8;
  localparam int          ADDR_BYTES   = 3;
endpackage

// File: rtl/lqc_tag.sv
module lqc_tag #(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 1024,
  localparam int IDX_W     = $clog2(LINE_BYTES / 4)
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] diff;
  logic [1:0]        unused_low;

  assign diff       = addr - base;
  assign unused_low = diff[1:0];
  assign hit        = valid && (addr >= base) && (diff <= ADDR_W'(LINE_BYTES - 4));
  assign idx        = diff[IDX_W+1:2];
endmodule

// File: rtl/lqc_line_buf.sv
module lqc_line_buf #(
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lqc_cmd_gen.sv
module lqc_cmd_gen #(
  parameter int CNT_W = 10
) (
  input  logic [7:0]       instr,
  input  logic [23:0]      faddr,
  input  logic             mode_en,
  input  logic [7:0]       mode_val,
  input  logic [2:0]       dummies,
  input  logic             data_ph,
  input  logic [CNT_W-1:0] pos,
  output logic [7:0]       byte_out,
  output logic             hdr_last
);
  localparam int HDR_FIXED = 1 + lqc_pkg::ADDR_BYTES;

  logic [CNT_W-1:0] last_pos;

  assign last_pos = CNT_W'(HDR_FIXED - 1) + CNT_W'(mode_en) + CNT_W'(dummies);
  assign hdr_last = (pos == last_pos);

  always_comb begin
    byte_out = 8'h00;
    if (!data_ph) begin
      case (pos)
        CNT_W'(0): byte_out = instr;
        CNT_W'(1): byte_out = faddr[23:16];
        CNT_W'(2): byte_out = faddr[15:8];
        CNT_W'(3): byte_out = faddr[7:0];
        CNT_W'(4): byte_out = mode_en ? mode_val : 8'h00;
        default:   byte_out = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/lin_flash_cache.sv
module lin_flash_cache #(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 1024,
  parameter int BUS_CNT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              cs_n,
  output logic              upper_page
);
  import lqc_pkg::*;

  localparam int CNT_W  = $clog2(LINE_BYTES);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BUS_SH = $clog2(BUS_CNT);

  lqc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              data_ph;
  logic [ADDR_W-1:0] req_addr, base_q;
  logic              valid_q, stale_q, cs_n_q, page_q;
  logic [23:0]       pack_q;
  logic [7:0]        cfg_instr, cfg_mode;
  logic              cfg_mode_en, cfg_dual;
  logic [2:0]        cfg_dummy;

  logic              hit, hdr_last, buf_we;
  logic [IDX_W-1:0]  hit_idx;
  logic [ADDR_W-1:0] flash_addr;
  logic [31:0]       buf_q;

  wire unused_cfg_bits = ^{cfg_wdata[31], cfg_wdata[29:26], cfg_wdata[24], cfg_wdata[15:11],
                           flash_addr[ADDR_W-1:25]};

  assign flash_addr = cfg_dual ? (req_addr >> BUS_SH) : req_addr;

  lqc_tag #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_tag (
    .valid(valid_q), .base(base_q), .addr(req_addr), .hit(hit), .idx(hit_idx)
  );

  lqc_cmd_gen #(.CNT_W(CNT_W)) u_cmd (
    .instr(cfg_instr), .faddr(flash_addr[23:0]), .mode_en(cfg_mode_en),
    .mode_val(cfg_mode), .dummies(cfg_dummy), .data_ph(data_ph), .pos(cnt),
    .byte_out(tx_byte), .hdr_last(hdr_last)
  );

  assign buf_we = (state == ST_WAIT) && rx_valid && data_ph && (cnt[1:0] == 2'd3);

  lqc_line_buf #(.DEPTH(WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(cnt[CNT_W-1:2]), .wdata({rx_byte, pack_q}),
    .raddr(hit_idx), .rdata(buf_q)
  );

  assign rd_ready   = (state == ST_IDLE);
  assign rd_valid   = (state == ST_OUT);
  assign rd_data    = buf_q;
  assign tx_valid   = (state == ST_SEND);
  assign cs_n       = cs_n_q;
  assign upper_page = page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      data_ph     <= 1'b0;
      req_addr    <= '0;
      base_q      <= '0;
      valid_q     <= 1'b0;
      stale_q     <= 1'b0;
      cs_n_q      <= 1'b1;
      page_q      <= 1'b0;
      pack_q      <= '0;
      cfg_instr   <= CFG_RESET[7:0];
      cfg_mode    <= CFG_RESET[CFG_MODE_LSB +: 8];
      cfg_mode_en <= CFG_RESET[CFG_MODE_BIT];
      cfg_dual    <= CFG_RESET[CFG_DUAL_BIT];
      cfg_dummy   <= CFG_RESET[CFG_DUMY_LSB +: 3];
    end else begin
      unique case (state)
        ST_IDLE: if (rd_req) begin
          req_addr <= rd_addr;
          state    <= ST_CHECK;
        end
        ST_CHECK: if (hit) begin
          state <= ST_OUT;
        end else begin
          cs_n_q  <= 1'b0;
          page_q  <= flash_addr[24];
          cnt     <= '0;
          data_ph <= 1'b0;
          stale_q <= 1'b0;
          state   <= ST_SEND;
        end
        ST_OUT:  state <= ST_IDLE;
        ST_SEND: if (tx_ready) state <= ST_WAIT;
        ST_WAIT: if (rx_valid) begin
          if (!data_ph) begin
            if (hdr_last) begin
              data_ph <= 1'b1;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
            state <= ST_SEND;
          end else begin
            case (cnt[1:0])
              2'd0:    pack_q[7:0]   <= rx_byte;
              2'd1:    pack_q[15:8]  <= rx_byte;
              2'd2:    pack_q[23:16] <= rx_byte;
              default: pack_q        <= pack_q;
            endcase
            if (cnt == CNT_W'(LINE_BYTES - 1)) begin
              cs_n_q  <= 1'b1;
              page_q  <= 1'b0;
              base_q  <= req_addr;
              valid_q <= !stale_q;
              state   <= ST_CHECK;
            end else begin
              cnt   <= cnt + 1'b1;
              state <= ST_SEND;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (cfg_we) begin
        cfg_instr   <= cfg_wdata[7:0];
        cfg_mode    <= cfg_wdata[CFG_MODE_LSB +: 8];
        cfg_mode_en <= cfg_wdata[CFG_MODE_BIT];
        cfg_dual    <= cfg_wdata[CFG_DUAL_BIT];
        cfg_dummy   <= cfg_wdata[CFG_DUMY_LSB +: 3];
        valid_q     <= 1'b0;
        stale_q     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lqc_chk.sv
module lqc_chk (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic rd_ready,
  input logic rd_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic cs_n,
  input logic upper_page
);
  // R10
  tx_sel_chk: assert property (@(posedge clk) disable iff (rst) tx_valid |-> !cs_n);
  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst) !cs_n |-> !rd_ready);
  // R7
  page_idle_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !upper_page);
  // R3
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid);
  // R6
  one_byte_chk: assert property (@(posedge clk) disable iff (rst) (tx_valid && tx_ready) |=> !tx_valid);
  // R9
  accept_chk: assert property (@(posedge clk) disable iff (rst) (rd_req && rd_ready) |=> !rd_ready);
  // R3
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst) rd_valid |-> cs_n);
endmodule

bind lin_flash_cache lqc_chk u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .cs_n(cs_n), .upper_page(upper_page)
);

// File: tb/lin_flash_cache_tb.sv
module lin_flash_cache_tb;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_ready, rd_valid;
  logic [31:0]   rd_data;
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_ready = 1'b1;
  logic          rx_valid;
  logic [7:0]    rx_byte;
  logic          cs_n, upper_page;

  always #5 clk = ~clk;

  lin_flash_cache #(.ADDR_W(AW), .LINE_BYTES(1024), .BUS_CNT(2)) u_dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .cs_n(cs_n), .upper_page(upper_page)
  );

  function automatic logic [7:0] fb(input logic [24:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ (a[23:16] * 8'd3) ^ {a[24], 7'h15};
  endfunction

  // behavioural flash responder
  int          hlen = 7;
  int          nb, last_nb, sess_cnt;
  logic        prev_cs, pg_seen, nz_data;
  logic [7:0]  hlog [16];

  always @(posedge clk) begin
    if (rst) begin
      nb <= 0; last_nb <= 0; sess_cnt <= 0; prev_cs <= 1'b1;
      pg_seen <= 1'b0; nz_data <= 1'b0; rx_valid <= 1'b0; rx_byte <= 8'h00;
    end else begin
      prev_cs  <= cs_n;
      rx_valid <= 1'b0;
      if (prev_cs && !cs_n) begin
        sess_cnt <= sess_cnt + 1;
        nz_data  <= 1'b0;
      end
      if (!prev_cs && cs_n) last_nb <= nb;
      if (cs_n) nb <= 0;
      if (tx_valid && tx_ready) begin
        if (nb < 16) hlog[nb] <= tx_byte;
        if (nb == 0) pg_seen <= upper_page;
        if (nb >= hlen && tx_byte != 8'h00) nz_data <= 1'b1;
        rx_byte  <= (nb < hlen) ? 8'hEE
                    : fb({upper_page, hlog[1], hlog[2], hlog[3]} + 25'(nb - hlen));
        rx_valid <= 1'b1;
        nb       <= nb + 1;
      end
    end
  end

  int         nchk = 0, nfail = 0;
  bit         done = 0;
  logic [31:0] cur_cfg = 32'h03A0_02EB;
  int         sh = 0;
  bit         m_valid = 0;
  logic [AW-1:0] m_base = '0;
  logic [31:0] r_data;
  int         r_lat;
  bit         r_busy;

  localparam logic [AW-1:0] V_ADDR [8] = '{26'h0000100, 26'h0000104, 26'h00004FC, 26'h0000500,
                                           26'h00004FC, 26'h00008F8, 26'h1000010, 26'h1000020};
  localparam bit            V_MISS [8] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] base, input logic [AW-1:0] a, input int s);
    logic [AW-1:0] fa;
    fa = (base >> s) + (((a - base) >> 2) << 2);
    return {fb(fa[24:0] + 25'd3), fb(fa[24:0] + 25'd2), fb(fa[24:0] + 25'd1), fb(fa[24:0])};
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = v;
    sh      = v[30] ? 1 : 0;
    hlen    = 4 + int'(v[25]) + int'(v[10:8]);
    m_valid = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit poke);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    r_lat  = 1; r_busy = 0;
    while (!rd_valid && r_lat < 5000) begin
      if (!cs_n && rd_ready) r_busy = 1;
      if (poke && r_lat == 200) begin rd_req = 1'b1; rd_addr = 26'h0000400; end
      if (poke && r_lat == 260) rd_req = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    r_data = rd_data;
  endtask

  task automatic run_vec(input logic [AW-1:0] a, input bit exp_miss, input bit poke);
    int s0;
    logic [AW-1:0] fa;
    bit ok_d;
    int mpos;
    s0 = sess_cnt;
    do_read(a, poke);
    chk(rd_valid == 1'b1, "R3 response seen", rd_valid, 1);
    chk((sess_cnt != s0) == exp_miss, exp_miss ? "R4 miss traffic" : "R3 hit no traffic",
        sess_cnt - s0, exp_miss);
    if (exp_miss) begin
      m_base = a; m_valid = 1;
      fa = a >> sh;
      chk(hlog[0] == cur_cfg[7:0], "R4 instruction", hlog[0], cur_cfg[7:0]);
      chk({hlog[1], hlog[2], hlog[3]} == fa[23:0], "R4 address bytes",
          {hlog[1], hlog[2], hlog[3]}, fa[23:0]);
      mpos = 4;
      if (cur_cfg[25]) begin
        chk(hlog[4] == cur_cfg[23:16], "R4 mode byte", hlog[4], cur_cfg[23:16]);
        mpos = 5;
      end
      ok_d = 1;
      for (int i = mpos; i < hlen; i++) if (hlog[i] != 8'h00) ok_d = 0;
      chk(ok_d, "R4 dummy bytes zero", ok_d, 1);
      chk(last_nb == hlen + 1024, "R6 byte count", last_nb, hlen + 1024);
      chk(!nz_data, "R6 data phase sends zeros", nz_data, 0);
      chk(pg_seen == fa[24], "R5 upper page during refill", pg_seen, fa[24]);
      chk(!r_busy, "R9 ready low during refill", r_busy, 0);
    end else begin
      chk(r_lat == 2, "R3 hit latency", r_lat, 2);
    end
    chk(r_data == exp_word(m_base, a, sh), exp_miss ? "R6 refill data" : "R3 hit data",
        r_data, exp_word(m_base, a, sh));
    chk(cs_n && !upper_page, "R7 select and page released", {cs_n, upper_page}, 2'b10);
    if (poke) begin
      ok_d = 1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (rd_valid) ok_d = 0;
      end
      chk(ok_d && rd_ready, "R9 request during refill ignored", {ok_d, rd_ready}, 2'b11);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R1 act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_ready && !rd_valid && !tx_valid && cs_n && !upper_page, "R1 reset outputs",
        {rd_ready, rd_valid, tx_valid, cs_n, upper_page}, 5'b10010);

    for (int v = 0; v < 8; v++) begin
      run_vec(V_ADDR[v], V_MISS[v], 1'b0);
      if (v == 0) begin
        // R2 reset configuration framing
        chk(hlog[0] == 8'hEB && hlog[4] == 8'hA0 && last_nb == 7 + 1024, "R2 reset config",
            {hlog[0], hlog[4]}, 16'hEBA0);
      end
    end

    // R8 invalidation by config write, same value
    write_cfg(32'h03A0_02EB);
    run_vec(26'h1000020, 1'b1, 1'b0);

    // R5 dual-bus division, no mode byte, no dummies
    write_cfg(32'h4000_0003);
    run_vec(26'h2000040, 1'b1, 1'b0);
    run_vec(26'h2000044, 1'b0, 1'b0);

    // R9 request raised during refill
    write_cfg(32'h0200_0103);
    run_vec(26'h0000000, 1'b1, 1'b1);
    run_vec(26'h00003FC, 1'b0, 1'b0);

    finish_run();
  end
endmodule